// File: doc/BRIEF.md
# Alarm Compare and Event Interrupt Unit

This unit sits beside a time-of-day counter and turns its state into a single interrupt line. The running time word and calendar word arrive as inputs in packed BCD, together with one-cycle strobes from the counter: a second tick, a time event, a calendar event and an update acknowledge. Software programs two alarm words through a small register port. Each alarm field carries its own enable bit. On every second tick, the unit compares the enabled fields with the current time and calendar. The compare uses the time and calendar values present in the tick cycle.

Every condition sets a sticky flag in a status register. A flag stays set until software writes a one to the matching bit of a clear register. Two separate registers set and clear bits of an interrupt mask, and the mask can be read back. The interrupt output is high while any flag is set together with its mask bit. A read-only check register reports which of the four words (current time, current calendar, time alarm, calendar alarm) hold out-of-range BCD content.

Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational from `rd_addr`. Register word addresses are: 0 time alarm, 1 calendar alarm, 2 status (read), 3 flag clear (write), 4 mask set (write), 5 mask clear (write), 6 mask (read), 7 content check (read). Unused read addresses and write-only addresses return zero.

Top module: `aei_unit`

## Requirements
- R1: After reset, the status, mask, time-alarm and calendar-alarm registers read zero and `irq` is low.
- R2: The time alarm (address 0) holds seconds in [6:0], minutes in [14:8] and hours in [21:16], laid out as in `cur_time`. Bit 7 enables the seconds compare, bit 15 the minutes compare and bit 23 the hours compare. An enabled field matches only when it equals the current field. The word reads back as written.
- R3: The calendar alarm (address 1) holds month in [20:16] and date in [29:24], with bit 23 enabling the month compare and bit 31 the date compare. It has no year field, so the year bits [15:8] of `cur_cal` never affect a match.
- R4: Status bit 1 (alarm) sets at the edge of every cycle in which `sec_tick` is high, at least one alarm field is enabled, and every enabled field matches. A disabled field counts as matching. With no field enabled, the alarm never sets.
- R5: A strobe on `upd_ack`, `sec_tick`, `time_evt` or `cal_evt` sets status bit 0, 2, 3 or 4 respectively at the next edge. Status is read at address 2.
- R6: Writing address 3 clears each status bit whose data bit is one. Bits written as zero keep their value.
- R7: When a flag's set condition and a clear of that bit occur in the same cycle, the flag ends up set.
- R8: Writing ones to address 4 sets the matching mask bits. Writing ones to address 5 clears them. Address 6 reads back the mask. Zero data bits leave the mask unchanged.
- R9: `irq` is high exactly while some status bit and its mask bit are both one. Clearing the mask drops `irq` even if the flag stays set.
- R10: Address 7 reads a 4-bit error vector with these bits: bit 0 for bad `cur_time`, bit 1 for bad `cur_cal`, bit 2 for a bad time alarm, bit 3 for a bad calendar alarm. Time fields must be BCD with seconds and minutes 00-59 and hours 00-23. Calendar fields must be BCD with month 01-12 and date 01-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for reads |
| rd_data | output | 32 | Combinational read data |
| cur_time | input | 32 | Current time word, BCD seconds/minutes/hours |
| cur_cal | input | 32 | Current calendar word, BCD year/month/date |
| sec_tick | input | 1 | One-cycle second strobe |
| time_evt | input | 1 | One-cycle time event strobe |
| cal_evt | input | 1 | One-cycle calendar event strobe |
| upd_ack | input | 1 | One-cycle update acknowledge strobe |
| irq | output | 1 | Interrupt request |

## Verification
The alarm compare is tested with four kinds of input. A full time match with all three time enables set must raise the alarm. The same alarm word with only the minute changed must not, which shows that each enabled field is really compared. A seconds-only enable against a wildly different hour and minute must raise the alarm, which shows that disabled fields are ignored. A word with no enables against an exact value must not raise it. Calendar patterns differ in date or only in year, which tells a real date compare apart from the absent year field. The flag and mask patterns cover partial clears, a set colliding with a clear, and a masked flag that stays set, which separates status storage from interrupt gating.

// File: rtl/aei_pkg.sv
package aei_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_EVT = 5;
    localparam int NUM_CHK = 4;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_TALM = 3'd0;
    localparam logic [ADDR_W-1:0] A_CALM = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MSET = 3'd4;
    localparam logic [ADDR_W-1:0] A_MCLR = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd6;
    localparam logic [ADDR_W-1:0] A_CHK  = 3'd7;

    // status bit positions
    localparam int EV_UPD  = 0;
    localparam int EV_ALM  = 1;
    localparam int EV_SEC  = 2;
    localparam int EV_TIME = 3;
    localparam int EV_CAL  = 4;

    // alarm enable bit positions
    localparam int EN_SEC  = 7;
    localparam int EN_MIN  = 15;
    localparam int EN_HOUR = 23;
    localparam int EN_MON  = 23;
    localparam int EN_DATE = 31;

    // one BCD byte: low digit legal and value inside [lo, hi]
    function automatic logic bcd_in_range(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic time_word_ok(logic [DATA_W-1:0] w);
        return bcd_in_range({1'b0, w[6:0]},   8'h00, 8'h59) &&
               bcd_in_range({1'b0, w[14:8]},  8'h00, 8'h59) &&
               bcd_in_range({2'b0, w[21:16]}, 8'h00, 8'h23);
    endfunction

    function automatic logic cal_word_ok(logic [DATA_W-1:0] w);
        return bcd_in_range({3'b0, w[20:16]}, 8'h01, 8'h12) &&
               bcd_in_range({2'b0, w[29:24]}, 8'h01, 8'h31);
    endfunction

endpackage

// File: rtl/aei_alarm_match.sv
module aei_alarm_match
    import aei_pkg::*;
(
    input  logic [DATA_W-1:0] talm,
    input  logic [DATA_W-1:0] calm,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] cur_cal,
    input  logic              sec_tick,
    output logic              alarm_hit
);
    localparam int NUM_FLD = 5;

    logic [NUM_FLD-1:0] fld_en;
    logic [NUM_FLD-1:0] fld_eq;
    logic [NUM_FLD-1:0] fld_ok;

    always_comb begin
        fld_en = {calm[EN_DATE], calm[EN_MON], talm[EN_HOUR], talm[EN_MIN], talm[EN_SEC]};
        fld_eq[0] = (talm[6:0]   == cur_time[6:0]);
        fld_eq[1] = (talm[14:8]  == cur_time[14:8]);
        fld_eq[2] = (talm[21:16] == cur_time[21:16]);
        fld_eq[3] = (calm[20:16] == cur_cal[20:16]);
        fld_eq[4] = (calm[29:24] == cur_cal[29:24]);
    end

    for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
        assign fld_ok[i] = !fld_en[i] || fld_eq[i];
    end

    assign alarm_hit = sec_tick && (|fld_en) && (&fld_ok);

endmodule

// File: rtl/aei_evt_regs.sv
module aei_evt_regs
    import aei_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] en_vec,
    input  logic [N-1:0] dis_vec,
    output logic [N-1:0] stat,
    output logic [N-1:0] mask,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat[i] <= 1'b0;
            end else if (set_vec[i]) begin
                stat[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                stat[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= 1'b0;
            end else if (en_vec[i]) begin
                mask[i] <= 1'b1;
            end else if (dis_vec[i]) begin
                mask[i] <= 1'b0;
            end
        end
    end

    assign irq = |(stat & mask);

endmodule

// File: rtl/aei_entry_check.sv
module aei_entry_check
    import aei_pkg::*;
(
    input  logic [DATA_W-1:0]  cur_time,
    input  logic [DATA_W-1:0]  cur_cal,
    input  logic [DATA_W-1:0]  talm,
    input  logic [DATA_W-1:0]  calm,
    output logic [NUM_CHK-1:0] entry_err
);
    always_comb begin
        entry_err[0] = !time_word_ok(cur_time);
        entry_err[1] = !cal_word_ok(cur_cal);
        entry_err[2] = !time_word_ok(talm);
        entry_err[3] = !cal_word_ok(calm);
    end

endmodule

// File: rtl/aei_unit.sv
module aei_unit
    import aei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] cur_cal,
    input  logic              sec_tick,
    input  logic              time_evt,
    input  logic              cal_evt,
    input  logic              upd_ack,
    output logic              irq
);
    localparam int PAD_E = DATA_W - NUM_EVT;
    localparam int PAD_C = DATA_W - NUM_CHK;

    logic [DATA_W-1:0]  talm_q;
    logic [DATA_W-1:0]  calm_q;
    logic               alarm_hit;
    logic [NUM_EVT-1:0] set_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] en_vec;
    logic [NUM_EVT-1:0] dis_vec;
    logic [NUM_EVT-1:0] stat;
    logic [NUM_EVT-1:0] mask;
    logic [NUM_CHK-1:0] entry_err;

    // alarm word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            talm_q <= '0;
            calm_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_TALM) talm_q <= wr_data;
            if (wr_addr == A_CALM) calm_q <= wr_data;
        end
    end

    // command decode
    always_comb begin
        clr_vec = (wr_en && wr_addr == A_CLR)  ? wr_data[NUM_EVT-1:0] : '0;
        en_vec  = (wr_en && wr_addr == A_MSET) ? wr_data[NUM_EVT-1:0] : '0;
        dis_vec = (wr_en && wr_addr == A_MCLR) ? wr_data[NUM_EVT-1:0] : '0;
        set_vec          = '0;
        set_vec[EV_UPD]  = upd_ack;
        set_vec[EV_ALM]  = alarm_hit;
        set_vec[EV_SEC]  = sec_tick;
        set_vec[EV_TIME] = time_evt;
        set_vec[EV_CAL]  = cal_evt;
    end

    aei_alarm_match u_match (
        .talm      (talm_q),
        .calm      (calm_q),
        .cur_time  (cur_time),
        .cur_cal   (cur_cal),
        .sec_tick  (sec_tick),
        .alarm_hit (alarm_hit)
    );

    aei_evt_regs #(.N(NUM_EVT)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_vec  (en_vec),
        .dis_vec (dis_vec),
        .stat    (stat),
        .mask    (mask),
        .irq     (irq)
    );

    aei_entry_check u_chk_entry (
        .cur_time  (cur_time),
        .cur_cal   (cur_cal),
        .talm      (talm_q),
        .calm      (calm_q),
        .entry_err (entry_err)
    );

    // read mux
    always_comb begin
        unique case (rd_addr)
            A_TALM:  rd_data = talm_q;
            A_CALM:  rd_data = calm_q;
            A_STAT:  rd_data = {{PAD_E{1'b0}}, stat};
            A_MASK:  rd_data = {{PAD_E{1'b0}}, mask};
            A_CHK:   rd_data = {{PAD_C{1'b0}}, entry_err};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/aei_unit_chk.sv
module aei_unit_chk
    import aei_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic               sec_tick,
    input logic               time_evt,
    input logic               alarm_hit,
    input logic [NUM_EVT-1:0] stat,
    input logic [NUM_EVT-1:0] mask,
    input logic               irq
);
    p_alarm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> stat[EV_ALM]);

    p_alarm_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[EV_ALM]) |-> $past(sec_tick));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLR && wr_data[EV_TIME] && !time_evt) |=> !stat[EV_TIME]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        time_evt |=> stat[EV_TIME]);

    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSET && wr_data[EV_CAL]) |=> mask[EV_CAL]);

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == A_MSET || wr_addr == A_MCLR)) |=> $stable(mask));

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MCLR && (&wr_data[NUM_EVT-1:0])) |=> !irq);

endmodule

bind aei_unit aei_unit_chk u_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sec_tick  (sec_tick),
    .time_evt  (time_evt),
    .alarm_hit (alarm_hit),
    .stat      (stat),
    .mask      (mask),
    .irq       (irq)
);

// File: tb/aei_unit_tb.sv
module aei_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] cur_time = '0;
    logic [31:0] cur_cal = '0;
    logic        sec_tick = 1'b0;
    logic        time_evt = 1'b0;
    logic        cal_evt = 1'b0;
    logic        upd_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aei_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cur_time (cur_time),
        .cur_cal  (cur_cal),
        .sec_tick (sec_tick),
        .time_evt (time_evt),
        .cal_evt  (cal_evt),
        .upd_ack  (upd_ack),
        .irq      (irq)
    );

    function automatic logic [31:0] mk_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
        return {8'h00, h, m, s};
    endfunction

    function automatic logic [31:0] mk_cal(logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        return {d, mo, y, 8'h20};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // bits: 0 upd_ack, 1 sec_tick, 2 time_evt, 3 cal_evt
    task automatic strobe(logic [3:0] s);
        @(negedge clk);
        upd_ack = s[0]; sec_tick = s[1]; time_evt = s[2]; cal_evt = s[3];
        @(negedge clk);
        upd_ack = 0; sec_tick = 0; time_evt = 0; cal_evt = 0;
    endtask

    task automatic expect_stat(string req, logic [31:0] exp);
        logic [31:0] v;
        reg_rd(3'd2, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        expect_stat("R1 status after reset", 32'h0);
        reg_rd(3'd6, v); check("R1 mask after reset", v, 32'h0);
        reg_rd(3'd0, v); check("R1 time alarm after reset", v, 32'h0);
        reg_rd(3'd1, v); check("R1 cal alarm after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        // zero calendar words have month 00 and date 00
        reg_rd(3'd7, v); check("R10 check reg after reset", v, 32'hA);
    endtask

    task automatic t_time_alarm;
        logic [31:0] w;
        logic [31:0] v;
        w = mk_time(8'h08, 8'h15, 8'h30) | (32'h1 << 7) | (32'h1 << 15) | (32'h1 << 23);
        reg_wr(3'd0, w);
        reg_rd(3'd0, v); check("R2 time alarm readback", v, w);
        cur_time = mk_time(8'h08, 8'h15, 8'h30);
        strobe(4'b0010);
        expect_stat("R2 full time match", 32'h06);
        reg_wr(3'd3, 32'h1F);
        expect_stat("R6 clear all", 32'h0);
        cur_time = mk_time(8'h08, 8'h16, 8'h30);
        strobe(4'b0010);
        expect_stat("R2 minute mismatch", 32'h04);
        reg_wr(3'd3, 32'h1F);
    endtask

    task automatic t_partial_enable;
        reg_wr(3'd0, 32'h30 | (32'h1 << 7));
        cur_time = mk_time(8'h23, 8'h59, 8'h30);
        strobe(4'b0010);
        expect_stat("R4 disabled fields match", 32'h06);
        reg_wr(3'd3, 32'h1F);
        // match present but no tick: no alarm
        @(negedge clk); @(negedge clk);
        expect_stat("R4 no tick no alarm", 32'h0);
        reg_wr(3'd0, 32'h30);
        strobe(4'b0010);
        expect_stat("R4 no enables never fires", 32'h04);
        reg_wr(3'd3, 32'h1F);
    endtask

    task automatic t_cal_alarm;
        logic [31:0] w;
        w = mk_cal(8'h14, 8'h07, 8'h00) | (32'h1 << 23) | (32'h1 << 31);
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd1, w);
        cur_cal = mk_cal(8'h14, 8'h07, 8'h24);
        strobe(4'b0010);
        expect_stat("R3 month/date match", 32'h06);
        reg_wr(3'd3, 32'h1F);
        cur_cal = mk_cal(8'h14, 8'h07, 8'h99);
        strobe(4'b0010);
        expect_stat("R3 year ignored", 32'h06);
        reg_wr(3'd3, 32'h1F);
        cur_cal = mk_cal(8'h15, 8'h07, 8'h24);
        strobe(4'b0010);
        expect_stat("R3 date mismatch", 32'h04);
        reg_wr(3'd3, 32'h1F);
        reg_wr(3'd1, 32'h0);
    endtask

    task automatic t_events;
        strobe(4'b1101);
        expect_stat("R5 upd/time/cal events", 32'h19);
        reg_wr(3'd3, 32'h01);
        expect_stat("R6 partial clear", 32'h18);
        reg_wr(3'd3, 32'h18);
        expect_stat("R6 remaining clear", 32'h0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        time_evt = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h08;
        @(negedge clk);
        time_evt = 1'b0; wr_en = 1'b0; wr_data = '0;
        expect_stat("R7 set beats clear", 32'h08);
        reg_wr(3'd3, 32'h08);
        expect_stat("R7 later clear", 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] v;
        reg_wr(3'd4, 32'h12);
        reg_rd(3'd6, v); check("R8 mask set", v, 32'h12);
        reg_wr(3'd5, 32'h02);
        reg_rd(3'd6, v); check("R8 mask clear", v, 32'h10);
        check("R9 irq low no flag", {31'b0, irq}, 32'h0);
        strobe(4'b0100);
        check("R9 irq low unmasked flag", {31'b0, irq}, 32'h0);
        strobe(4'b1000);
        check("R9 irq high masked flag", {31'b0, irq}, 32'h1);
        reg_wr(3'd5, 32'h10);
        check("R9 irq low after disable", {31'b0, irq}, 32'h0);
        expect_stat("R9 flags kept", 32'h18);
        reg_wr(3'd4, 32'h10);
        check("R9 irq after re-enable", {31'b0, irq}, 32'h1);
        reg_wr(3'd3, 32'h1F);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_entry_check;
        logic [31:0] v;
        cur_time = mk_time(8'h12, 8'h00, 8'h00);
        cur_cal  = mk_cal(8'h01, 8'h01, 8'h00);
        reg_wr(3'd1, mk_cal(8'h31, 8'h12, 8'h00));
        reg_wr(3'd0, mk_time(8'h23, 8'h59, 8'h59));
        reg_rd(3'd7, v); check("R10 all valid", v, 32'h0);
        cur_time = mk_time(8'h24, 8'h00, 8'h00);
        reg_rd(3'd7, v); check("R10 hour 24", v, 32'h1);
        cur_time = mk_time(8'h12, 8'h00, 8'h5A);
        cur_cal  = mk_cal(8'h01, 8'h13, 8'h00);
        reg_rd(3'd7, v); check("R10 bad digit and month", v, 32'h3);
        cur_time = mk_time(8'h12, 8'h00, 8'h00);
        cur_cal  = mk_cal(8'h01, 8'h01, 8'h00);
        reg_wr(3'd0, mk_time(8'h00, 8'h60, 8'h00));
        reg_wr(3'd1, mk_cal(8'h32, 8'h01, 8'h00));
        reg_rd(3'd7, v); check("R10 bad alarm words", v, 32'hC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_time_alarm;
        t_partial_enable;
        t_cal_alarm;
        t_events;
        t_set_wins;
        t_mask_irq;
        t_entry_check;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule